// File: doc/BRIEF.md
# PMIC Software Command Channel

This block is one software-driven command slot in front of a PMIC serial-bus engine. Software uses a simple word-addressed register bus. It can first load a 32-bit payload, then write one 32-bit command word. The command word carries the command type, the direction, a 4-bit target ID, a byte count of one to four, and a 16-bit register address.

The channel hands the command to an abstract bus engine with a request/grant handshake. It then waits for the engine's single-cycle response. A write command finishes as soon as the response arrives. A read command stores the returned bytes and keeps them on show. The channel stays in a dedicated holding state until software writes 1 to the valid-clear register. The same register also frees a channel that was left stuck in that state.

The current state number appears in status bits [3:1]. A command that arrives while the channel is busy is dropped and raises a sticky error flag.

Top module: `pmic_cmd_chan`

## Requirements
- R1: After reset, status reads 0, the write-data, read-data and command registers read 0, and `eng_req_o` is low.
- R2: Register offsets are command 0x00, write data 0x04, read data 0x14, valid-clear 0x24 and status 0x28. Status bits [3:1] hold the state number: 0 idle, 1 requesting, 2 waiting for response, 6 read data valid. Status bit 0 is the error flag. Unmapped offsets read 0.
- R3: A command write in idle moves the state to 1 and raises `eng_req_o`. `eng_cmd_o` then shows the written word and is read back at 0x00. The request stays high every cycle until `eng_gnt_i` is seen.
- R4: The cycle after a grant, the state is 2 and `eng_req_o` is low. The state stays 2 until `eng_rsp_vld_i`.
- R5: A command with bit 29 = 1 is a write. `eng_wdata_o` shows the write-data register. On the response the channel goes straight to state 0 and never enters state 6.
- R6: A command with bit 29 = 0 is a read. On the response, the read-data register takes bytes 0 to N of `eng_rsp_data_i`, where N is command bits [17:16], with byte 0 in bits [7:0]. Higher bytes read 0. The state becomes 6.
- R7: State 6 holds until a write to offset 0x24 with bit 0 = 1, which returns the state to 0. A write with bit 0 = 0 has no effect. Read data stays readable after the release.
- R8: A command write outside idle is ignored: the state and the command register do not change. It sets status bit 0, which stays set until a status write with bit 0 = 1.
- R9: Writes to the write-data register are taken only in idle and ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| eng_req_o | output | 1 | Request to bus engine |
| eng_gnt_i | input | 1 | Engine accepts request |
| eng_cmd_o | output | 32 | Latched command word |
| eng_wdata_o | output | 32 | Write payload |
| eng_rsp_vld_i | input | 1 | Engine response strobe |
| eng_rsp_data_i | input | 32 | Engine read data |

## Verification
The bench uses the default ADDR_W of 12, so every mapped offset can be reached, and so can an unmapped one such as 0x3FC. Random grant and response latencies show that the request is held and the wait state is kept over many cycles. Random byte counts and directions cover every mask width and both completion paths. Directed steps issue commands and payload writes while the channel is busy, and attempt a release with bit 0 clear.

// File: rtl/pmic_chan_pkg.sv
`timescale 1ns/1ps
package pmic_chan_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NBYTES  = DATA_W / 8;
  localparam int unsigned DIR_BIT = 29;
  localparam int unsigned LEN_LSB = 16;
  localparam int unsigned LEN_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_WAIT    = 3'd2,
    ST_VLDHOLD = 3'd6
  } chan_state_e;
endpackage

// File: rtl/pmic_chan_fsm.sv
`timescale 1ns/1ps
module pmic_chan_fsm
  import pmic_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic              vld_clr_i,
  input  logic              eng_gnt_i,
  input  logic              eng_rsp_vld_i,
  output chan_state_e       state_o,
  output logic              cmd_rej_o,
  output logic              cap_o,
  output logic              eng_req_o,
  output logic [DATA_W-1:0] cmd_o
);
  chan_state_e state_q, state_d;
  logic [DATA_W-1:0] cmd_q;
  logic is_wr;

  assign is_wr     = cmd_q[DIR_BIT];
  assign eng_req_o = (state_q == ST_REQ);
  assign cmd_rej_o = cmd_wr_i && (state_q != ST_IDLE);
  assign cap_o     = (state_q == ST_WAIT) && eng_rsp_vld_i && !is_wr;
  assign state_o   = state_q;
  assign cmd_o     = cmd_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (cmd_wr_i) state_d = ST_REQ;
      ST_REQ:     if (eng_gnt_i) state_d = ST_WAIT;
      ST_WAIT:    if (eng_rsp_vld_i) state_d = is_wr ? ST_IDLE : ST_VLDHOLD;
      ST_VLDHOLD: if (vld_clr_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_wr_i && state_q == ST_IDLE) cmd_q <= cmd_i;
    end
  end

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_gnt_i |=> eng_req_o);
  p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT && !eng_rsp_vld_i |=> state_q == ST_WAIT);
  p_wr_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT && eng_rsp_vld_i && is_wr |=> state_q == ST_IDLE);
  p_vld_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_VLDHOLD && !vld_clr_i |=> state_q == ST_VLDHOLD);
  p_busy_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && state_q != ST_IDLE |=> $stable(cmd_q));
endmodule

// File: rtl/pmic_chan_rdcap.sv
`timescale 1ns/1ps
module pmic_chan_rdcap
  import pmic_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] masked;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign masked[8*b +: 8] = (b <= int'(len_i)) ? data_i[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= masked;
  end

  p_one_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && len_i == '0 |=> rdata_o[DATA_W-1:8] == '0);
  p_rd_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rdata_o));
endmodule

// File: rtl/pmic_cmd_chan.sv
`timescale 1ns/1ps
module pmic_cmd_chan
  import pmic_chan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned OFF_CMD   = 'h00,
  parameter int unsigned OFF_WDATA = 'h04,
  parameter int unsigned OFF_RDATA = 'h14,
  parameter int unsigned OFF_VCLR  = 'h24,
  parameter int unsigned OFF_STAT  = 'h28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              eng_req_o,
  input  logic              eng_gnt_i,
  output logic [31:0]       eng_cmd_o,
  output logic [31:0]       eng_wdata_o,
  input  logic              eng_rsp_vld_i,
  input  logic [31:0]       eng_rsp_data_i
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFF_WDATA);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFF_RDATA);
  localparam logic [ADDR_W-1:0] A_VCLR  = ADDR_W'(OFF_VCLR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  logic wr, wr_cmd, wr_wdata, wr_vclr, wr_stat;
  logic cmd_rej, cap;
  chan_state_e state;
  logic [DATA_W-1:0] wdata_q, rdata, cmd;
  logic err_q;

  assign wr       = bus_req_i && bus_we_i;
  assign wr_cmd   = wr && bus_addr_i == A_CMD;
  assign wr_wdata = wr && bus_addr_i == A_WDATA;
  assign wr_vclr  = wr && bus_addr_i == A_VCLR && bus_wdata_i[0];
  assign wr_stat  = wr && bus_addr_i == A_STAT && bus_wdata_i[0];

  pmic_chan_fsm u_fsm (
    .clk_i, .rst_ni,
    .cmd_wr_i(wr_cmd), .cmd_i(bus_wdata_i), .vld_clr_i(wr_vclr),
    .eng_gnt_i, .eng_rsp_vld_i,
    .state_o(state), .cmd_rej_o(cmd_rej), .cap_o(cap),
    .eng_req_o, .cmd_o(cmd)
  );

  pmic_chan_rdcap u_rdcap (
    .clk_i, .rst_ni, .cap_i(cap),
    .len_i(cmd[LEN_LSB +: LEN_W]), .data_i(eng_rsp_data_i), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_wdata && state == ST_IDLE) wdata_q <= bus_wdata_i;
      if (cmd_rej)      err_q <= 1'b1;
      else if (wr_stat) err_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      unique case (bus_addr_i)
        A_CMD:   bus_rdata_o = cmd;
        A_WDATA: bus_rdata_o = wdata_q;
        A_RDATA: bus_rdata_o = rdata;
        A_STAT:  bus_rdata_o = {28'd0, state, err_q};
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign eng_cmd_o   = cmd;
  assign eng_wdata_o = wdata_q;

  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd && state != ST_IDLE |=> err_q);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !wr_stat |=> err_q);
  p_wdata_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_wdata && state != ST_IDLE |=> $stable(wdata_q));
  p_legal_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state inside {ST_IDLE, ST_REQ, ST_WAIT, ST_VLDHOLD});
endmodule

// File: tb/pmic_cmd_chan_tb.sv
`timescale 1ns/1ps
module pmic_cmd_chan_tb;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [11:0] addr = 0;
  logic [31:0] wd = 0, rd;
  logic ereq, gnt = 0, rsp = 0;
  logic [31:0] ecmd, ewd, rspd = 0;
  int vec = 0, miss = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmic_cmd_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rd),
    .eng_req_o(ereq), .eng_gnt_i(gnt), .eng_cmd_o(ecmd), .eng_wdata_o(ewd),
    .eng_rsp_vld_i(rsp), .eng_rsp_data_i(rspd)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic bwr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wd = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic brd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; #1 d = rd; req = 0;
  endtask

  function automatic logic [31:0] stat(int st, bit e);
    return {28'd0, 3'(st), e};
  endfunction

  function automatic logic [31:0] mask(logic [31:0] d, int n);
    logic [31:0] m = 0;
    for (int b = 0; b <= n; b++) m[8*b +: 8] = 8'hFF;
    return d & m;
  endfunction

  task automatic pulse_gnt(); @(negedge clk); gnt = 1; @(negedge clk); gnt = 0; endtask
  task automatic pulse_rsp(logic [31:0] d);
    @(negedge clk); rsp = 1; rspd = d; @(negedge clk); rsp = 0;
  endtask

  task automatic run(bit dir, int len, logic [15:0] ra, logic [31:0] pay,
                     logic [31:0] rdat, int glat, int rlat);
    logic [31:0] v, c;
    c = {2'(len), dir, 1'b0, 4'(ra[3:0]), 6'd0, 2'(len), ra};
    c[31:30] = 2'(ra[5:4]);
    if (dir) bwr(12'h004, pay);
    bwr(12'h000, c);
    brd(12'h028, v); chk("R3 state1", v, stat(1, 0));
    chk("R3 eng_cmd", ecmd, c);
    chk("R3 req", {31'd0, ereq}, 1);
    for (int i = 0; i < glat; i++) @(negedge clk);
    chk("R3 req held", {31'd0, ereq}, 1);
    pulse_gnt();
    chk("R4 req low", {31'd0, ereq}, 0);
    for (int i = 0; i < rlat; i++) @(negedge clk);
    brd(12'h028, v); chk("R4 state2", v, stat(2, 0));
    if (dir) chk("R5 wdata out", ewd, pay);
    pulse_rsp(rdat);
    brd(12'h028, v);
    if (dir) chk("R5 write idle", v, stat(0, 0));
    else begin
      chk("R6 state6", v, stat(6, 0));
      brd(12'h014, v); chk("R6 rdata", v, mask(rdat, len));
      bwr(12'h024, 32'h1);
      brd(12'h028, v); chk("R7 release", v, stat(0, 0));
      brd(12'h014, v); chk("R7 rdata kept", v, mask(rdat, len));
    end
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      miss++; vec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    brd(12'h028, v); chk("R1 status", v, 0);
    brd(12'h004, v); chk("R1 wdata", v, 0);
    brd(12'h014, v); chk("R1 rdata", v, 0);
    brd(12'h000, v); chk("R1 cmd", v, 0);
    chk("R1 req", {31'd0, ereq}, 0);
    brd(12'h3FC, v); chk("R2 unmapped", v, 0);

    // directed read, 1 byte, with busy command, wdata write and bad release
    c0 = 32'h4300_0012;
    bwr(12'h000, c0);
    brd(12'h000, v); chk("R3 cmd readback", v, c0);
    pulse_gnt();
    bwr(12'h000, 32'hE5FF_FFFF);
    brd(12'h028, v); chk("R8 ignored+err", v, stat(2, 1));
    chk("R8 cmd kept", ecmd, c0);
    bwr(12'h004, 32'hDEAD_BEEF);
    brd(12'h004, v); chk("R9 wdata locked", v, 0);
    pulse_rsp(32'hA1B2_C3D4);
    brd(12'h014, v); chk("R6 one byte", v, 32'h0000_00D4);
    bwr(12'h024, 32'h0);
    brd(12'h028, v); chk("R7 bit0 clear ignored", v, stat(6, 1));
    bwr(12'h000, 32'h0000_0001);
    chk("R8 cmd kept in 6", ecmd, c0);
    bwr(12'h024, 32'h1);
    brd(12'h028, v); chk("R8 err sticky", v, stat(0, 1));
    bwr(12'h028, 32'h0);
    brd(12'h028, v); chk("R8 clear needs bit0", v, stat(0, 1));
    bwr(12'h028, 32'h1);
    brd(12'h028, v); chk("R8 err cleared", v, stat(0, 0));
    bwr(12'h004, 32'h1234_5678);
    brd(12'h004, v); chk("R9 wdata idle", v, 32'h1234_5678);

    for (int n = 0; n < 60; n++)
      run($urandom_range(0, 1), $urandom_range(0, 3), 16'($urandom),
          $urandom, $urandom, $urandom_range(0, 6), $urandom_range(0, 6));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule